// File: doc/BRIEF.md
# Block-Lock Write Guard

This block sits beside the serial sequencer of a small nonvolatile byte store. It keeps the one-byte protection register and answers, for each byte the sequencer wants to program, whether that byte may be written. The register sits at the reserved top address FFFFh. It holds a two-bit lock span that seals the upper quarter, the upper half or all of the data array. It also holds a lock-enable bit that lets the external protect pin freeze the register itself.

The sequencer gives the block the target address of each loaded byte, a strobe for every byte it loads, a commit strobe for the start of the nonvolatile cycle, the state of the write-enable latch, and the active-low protect pin. The block returns a combinational write permit for the current address, the register contents for readback, and a request to clear the write-enable latch. The array size (16, 64 or 128 Kbit) is a parameter. The register value after reset comes from a parameter that stands in for the retained state.

Top module: `blk_guard`

## Requirements
- R1: After reset the register reads as the reset parameter ANDed with 8'h8C. Bit 7 is the lock-enable bit, bits 3:2 are the lock span, and all other bits read 0.
- R2: The span encodes 00 as nothing locked, 01 as the top quarter, 10 as the top half and 11 as the whole array. An array address gets permit 1 only when it lies below the locked span.
- R3: The array holds KBITS*128 bytes (07FFh, 1FFFh or 3FFFh as top address). Any other address except FFFFh gets permit 0.
- R4: At FFFFh, permit is 0 exactly when the pin is low and the lock-enable bit is 1. Otherwise it is 1.
- R5: One byte loaded at FFFFh, followed by a commit while the latch input is 1, stores that byte ANDed with 8'h8C. The stored value is readable on the next cycle.
- R6: A second byte loaded while a register byte is pending aborts the operation. A later commit leaves the register unchanged.
- R7: While the pin is low and the lock-enable bit is 1, a commit leaves the whole register unchanged, the lock-enable bit included.
- R8: While the lock-enable bit is 0, the pin has no effect: the register stays writable and FFFFh keeps permit 1 with the pin low.
- R9: A pin low with the lock-enable bit 1 between loading the register byte and the commit cancels the pending byte, even if the pin is high again at commit.
- R10: The latch-clear output is 1 in the cycle after any of these: the hardware lock is active, an abort occurs, or a register commit is accepted.
- R11: A commit while the latch input is 0 leaves the register unchanged.
- R12: The permit for array addresses depends only on the span and the address, never on the pin or the lock-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Target byte address |
| byte_wr | input | 1 | One-cycle strobe: a byte for addr was loaded |
| byte_data | input | 8 | Loaded byte value |
| commit | input | 1 | One-cycle strobe: start of the nonvolatile cycle |
| wp_n | input | 1 | Protect pin, active low |
| wel | input | 1 | Current write-enable latch state |
| permit | output | 1 | Byte at addr may be written |
| creg_q | output | 8 | Register contents for readback |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
The hardest case to reach is a pin pulse that lands inside a register operation: after the byte is staged but before the commit, with the pin high again by the time the commit arrives. The bench drives this directly, with a single-cycle low pulse between the load task and the commit task, and then reads back the register. Permit is swept over the whole address space for every span setting, on three size variants at once. This covers the span boundaries, the above-array hole and the reserved address, with both pin states.

// File: rtl/guard_pkg.sv
// Shared constants and types for the block-lock write guard.
// Assumes a 16-bit byte address space with the register at the top address.
package guard_pkg;
    localparam int          LOCK_EN_BIT = 7;
    localparam int          SPAN_HI     = 3;
    localparam int          SPAN_LO     = 2;
    localparam logic [7:0]  CREG_MASK   = 8'h8C;
    localparam logic [15:0] CREG_ADDR   = 16'hFFFF;

    typedef enum logic [1:0] {
        SPAN_NONE    = 2'b00,
        SPAN_QUARTER = 2'b01,
        SPAN_HALF    = 2'b10,
        SPAN_ALL     = 2'b11
    } lock_span_e;

    // Address bits spanned by the array for a given size in Kbit.
    function automatic int array_aw(input int kbits);
        case (kbits)
            16:      return 11;
            128:     return 14;
            default: return 13;
        endcase
    endfunction
endpackage

// File: rtl/guard_span_dec.sv
// Decides whether an array address is writable under the current lock span.
// Assumes KBITS is 16, 64 or 128; the register address is handled by the caller.
module guard_span_dec
    import guard_pkg::*;
#(
    parameter int KBITS = 64
) (
    input  logic [15:0] addr,
    input  lock_span_e  span,
    output logic        array_ok
);
    localparam int AW = array_aw(KBITS);

    logic above_top;
    logic in_top_half;
    logic in_top_quarter;
    logic locked;

    // Detect addresses beyond the array (only when the array is narrower than 16 bits).
    generate
        if (AW < 16) begin : g_hole
            assign above_top = |addr[15:AW];
        end else begin : g_full
            assign above_top = 1'b0;
        end
    endgenerate

    assign in_top_half    = addr[AW-1];
    assign in_top_quarter = (addr[AW-1:AW-2] == 2'b11);

    // Map the span code onto the locked region.
    always_comb begin
        case (span)
            SPAN_NONE:    locked = 1'b0;
            SPAN_QUARTER: locked = in_top_quarter;
            SPAN_HALF:    locked = in_top_half;
            default:      locked = 1'b1;
        endcase
    end

    assign array_ok = !above_top && !locked;
endmodule

// File: rtl/guard_creg.sv
// Holds the protection register, stages a single register byte and commits it.
// Assumes byte_wr and commit are single-cycle strobes from the sequencer.
module guard_creg
    import guard_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_wr,
    input  logic       to_reg,
    input  logic [7:0] byte_data,
    input  logic       commit,
    input  logic       wel,
    input  logic       hw_lock,
    output logic [7:0] creg,
    output logic       wel_clr
);
    logic       pend;
    logic [7:0] stage;
    logic       abort;
    logic       accept;

    assign abort  = byte_wr && pend;
    assign accept = commit && pend && wel && !hw_lock;

    // Register value, staged byte, pending flag and latch-clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            creg    <= RST_VAL & CREG_MASK;
            pend    <= 1'b0;
            stage   <= 8'h00;
            wel_clr <= 1'b0;
        end else begin
            wel_clr <= hw_lock || abort || accept;
            if (accept) begin
                creg <= stage;
            end
            if (hw_lock || commit || abort) begin
                pend <= 1'b0;
            end else if (byte_wr && to_reg) begin
                pend  <= 1'b1;
                stage <= byte_data & CREG_MASK;
            end
        end
    end
endmodule

// File: rtl/blk_guard.sv
// Top of the block-lock write guard: combines span decode, register lock and
// the register store. Permit is combinational from address and register value.
module blk_guard
    import guard_pkg::*;
#(
    parameter int         KBITS   = 64,
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        byte_wr,
    input  logic [7:0]  byte_data,
    input  logic        commit,
    input  logic        wp_n,
    input  logic        wel,
    output logic        permit,
    output logic [7:0]  creg_q,
    output logic        wel_clr
);
    logic       is_reg;
    logic       hw_lock;
    logic       array_ok;
    lock_span_e span;

    assign is_reg  = (addr == CREG_ADDR);
    assign hw_lock = !wp_n && creg_q[LOCK_EN_BIT];
    assign span    = lock_span_e'(creg_q[SPAN_HI:SPAN_LO]);

    guard_span_dec #(.KBITS(KBITS)) u_dec (
        .addr     (addr),
        .span     (span),
        .array_ok (array_ok)
    );

    guard_creg #(.RST_VAL(RST_VAL)) u_creg (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_wr   (byte_wr),
        .to_reg    (is_reg),
        .byte_data (byte_data),
        .commit    (commit),
        .wel       (wel),
        .hw_lock   (hw_lock),
        .creg      (creg_q),
        .wel_clr   (wel_clr)
    );

    // Select register lock or array lock by address.
    assign permit = is_reg ? !hw_lock : array_ok;
endmodule

// File: rtl/guard_chk.sv
// Port-level properties of the write guard, bound onto every blk_guard.
module guard_chk #(
    parameter int KBITS = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        commit,
    input logic        wp_n,
    input logic        wel,
    input logic        permit,
    input logic [7:0]  creg_q,
    input logic        wel_clr
);
    localparam int TOP = KBITS * 128;

    // R1
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_q & 8'h73) == 8'h00);

    // R3
    hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) >= TOP && addr != 16'hFFFF) |-> !permit);

    // R4
    reg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 16'hFFFF && !wp_n && creg_q[7]) |-> !permit);

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && creg_q[7]) |=> $stable(creg_q));

    // R5
    commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(creg_q));

    // R11
    no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |=> $stable(creg_q));

    // R10
    clr_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && creg_q[7]) |=> wel_clr);
endmodule

bind blk_guard guard_chk #(.KBITS(KBITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .commit  (commit),
    .wp_n    (wp_n),
    .wel     (wel),
    .permit  (permit),
    .creg_q  (creg_q),
    .wel_clr (wel_clr)
);

// File: tb/blk_guard_tb.sv
module blk_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        byte_wr = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        commit = 1'b0;
    logic        wp_n = 1'b1;
    logic        wel = 1'b0;
    logic        permit, permit16, permit128;
    logic [7:0]  creg_q, creg16, creg128;
    logic        wel_clr, clr16, clr128;
    logic        idle = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    blk_guard #(.KBITS(64), .RST_VAL(8'hF5)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .byte_wr(byte_wr),
        .byte_data(byte_data), .commit(commit), .wp_n(wp_n), .wel(wel),
        .permit(permit), .creg_q(creg_q), .wel_clr(wel_clr));

    blk_guard #(.KBITS(16), .RST_VAL(8'h0C)) u_d16 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .byte_wr(idle),
        .byte_data(byte_data), .commit(idle), .wp_n(wp_n), .wel(idle),
        .permit(permit16), .creg_q(creg16), .wel_clr(clr16));

    blk_guard #(.KBITS(128), .RST_VAL(8'h08)) u_d128 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .byte_wr(idle),
        .byte_data(byte_data), .commit(idle), .wp_n(wp_n), .wel(idle),
        .permit(permit128), .creg_q(creg128), .wel_clr(clr128));

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_permit(input int kb, input logic [7:0] r,
                                      input logic pin, input logic [15:0] a);
        int top;
        int lo;
        top = kb * 128;
        if (a == 16'hFFFF) return !(!pin && r[7]);
        case (r[3:2])
            2'b00:   lo = top;
            2'b01:   lo = top * 3 / 4;
            2'b10:   lo = top / 2;
            default: lo = 0;
        endcase
        return int'(a) < lo;
    endfunction

    task automatic probe(input logic [15:0] a, input string req);
        addr = a;
        #1;
        chk({req, " 64K"},  permit,    exp_permit(64,  creg_q,  wp_n, a));
        chk({req, " 16K"},  permit16,  exp_permit(16,  creg16,  wp_n, a));
        chk({req, " 128K"}, permit128, exp_permit(128, creg128, wp_n, a));
    endtask

    // R2 R3 R4 R12: sweep of the address space plus the boundaries
    task automatic sweep(input string req);
        logic [15:0] edges [10] = '{16'h07FF, 16'h0800, 16'h17FF, 16'h1800,
            16'h1FFF, 16'h2000, 16'h2FFF, 16'h3FFF, 16'h4000, 16'hFFFF};
        for (int i = 0; i < 65536; i += 4) probe(16'(i), req);
        foreach (edges[k]) probe(edges[k], req);
    endtask

    task automatic load(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; byte_data = d; byte_wr = 1'b1;
        @(negedge clk);
        byte_wr = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset value masked
        chk("R1 reset 64K", creg_q, 8'h84);
        chk("R1 reset 16K", creg16, 8'h0C);
        chk("R1 reset 128K", creg128, 8'h08);
        chk("R10 idle clear", wel_clr, 0);
        sweep("R2 quarter pin high");

        // R5: single byte plus commit stores masked value
        wel = 1'b1;
        load(16'hFFFF, 8'h7B);
        do_commit();
        chk("R5 commit", creg_q, 8'h08);
        chk("R10 clear after commit", wel_clr, 1);
        sweep("R2 half");

        // R8: lock-enable 0, pin low ignored
        wp_n = 1'b0;
        sweep("R8 R12 pin low unlocked");
        load(16'hFFFF, 8'h8C);
        do_commit();
        chk("R8 write with pin low", creg_q, 8'h8C);

        // R7: hardware lock freezes the register
        @(negedge clk);
        chk("R10 clear under lock", wel_clr, 1);
        addr = 16'hFFFF; #1;
        chk("R4 register locked", permit, 0);
        load(16'hFFFF, 8'h00);
        do_commit();
        chk("R7 frozen", creg_q, 8'h8C);
        sweep("R12 all locked pin low");

        // R11: latch low blocks commit
        wp_n = 1'b1;
        wel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        addr = 16'hFFFF; #1;
        chk("R4 register open", permit, 1);
        load(16'hFFFF, 8'h04);
        do_commit();
        chk("R11 latch low", creg_q, 8'h8C);

        // R6: second byte aborts
        wel = 1'b1;
        @(negedge clk);
        chk("R10 no clear idle", wel_clr, 0);
        load(16'hFFFF, 8'h04);
        chk("R10 no clear single byte", wel_clr, 0);
        load(16'hFFFF, 8'h08);
        chk("R10 clear on abort", wel_clr, 1);
        do_commit();
        chk("R6 abort", creg_q, 8'h8C);

        // R9: pin pulse between load and commit cancels
        load(16'hFFFF, 8'h04);
        wp_n = 1'b0;
        @(negedge clk);
        wp_n = 1'b1;
        do_commit();
        chk("R9 cancelled", creg_q, 8'h8C);

        // R5: clean write clears lock-enable
        load(16'hFFFF, 8'h04);
        do_commit();
        chk("R5 final", creg_q, 8'h04);
        sweep("R2 quarter after write");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule